// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's-complement operands of width `W` and takes one recoding step per clock. When `start` is accepted, it captures the multiplicand and the multiplier. Over the next `W` cycles it looks at the low multiplier bit together with one extra history bit below it. From that pair it adds the multiplicand to the running accumulator, subtracts it, or leaves the accumulator alone. It then shifts the accumulator, the multiplier register and the history bit right by one place as a single arithmetic shift.

When the last step is done, the block captures the `2W`-bit signed product into an output register and raises `done` for one cycle. The product stays on the output until the next multiplication finishes. While a multiplication is in progress, new `start` requests are ignored. The multiplicand copy and the accumulator carry one guard bit, so the most negative multiplicand can be subtracted without wrapping.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is high and in the first cycle after reset is released, `done` is 0 and `product` is 0.
- R2: For every pair of signed operands, including -2^(W-1) on either or both sides, `product` equals the signed product `multiplicand * multiplier` as a 2W-bit two's-complement value.
- R3: When `start` is sampled high by a clock edge with the block idle, `done` is high after the W-th later edge. No earlier edge raises it.
- R4: `done` stays high for exactly one cycle per multiplication.
- R5: `start` pulses and operand changes that arrive while a multiplication is in progress have no effect. The running result, its completion time and the number of `done` pulses are all unchanged.
- R6: `product` changes only together with a `done` pulse. It holds its value while the block is idle and while the next multiplication is in progress.
- R7: 3 multiplied by -4 gives -12, which is 12'hFF4 for W=6.
- R8: In each step, a (low multiplier bit, history bit) pair of 10 subtracts the multiplicand from the accumulator and a pair of 01 adds it. Pairs 00 and 11 leave it unchanged. The old low multiplier bit then becomes the history bit, and the accumulator's sign bit is replicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiplication; accepted only when idle |
| multiplicand | input | W | Signed multiplicand, sampled when start is accepted |
| multiplier | input | W | Signed multiplier, sampled when start is accepted |
| product | output | 2W | Signed product of the last completed multiplication |
| done | output | 1 | One-cycle pulse when a new product is on `product` |

## Verification
The assertions assume that `start` is synchronous to `clk` and that the operand inputs matter only in the cycle where a `start` is accepted. The stepping checks also assume the controller is in its running state only between an accepted start and the final step. The bench changes every input on the falling edge, so each input is stable at the rising edge that samples it. It sweeps all operand pairs of a six-bit configuration and checks both the product and the latency of each one. It also sends extra `start` pulses with different operands in the middle of a run and changes the operands while idle, to show that the block ignores them.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        STEP_KEEP = 2'd0,
        STEP_ADD  = 2'd1,
        STEP_SUB  = 2'd2
    } step_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    typedef struct packed {
        logic enable;
        logic invert;
        logic carry_in;
    } addctl_t;

    function automatic step_e recode(input logic low_bit, input logic hist_bit);
        step_e s;
        case ({low_bit, hist_bit})
            2'b10:   s = STEP_SUB;
            2'b01:   s = STEP_ADD;
            default: s = STEP_KEEP;
        endcase
        return s;
    endfunction

    function automatic addctl_t step_to_ctl(input step_e s);
        addctl_t c;
        c.enable   = (s != STEP_KEEP);
        c.invert   = (s == STEP_SUB);
        c.carry_in = (s == STEP_SUB);
        return c;
    endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic    low_bit,
    input  logic    hist_bit,
    output step_e   step,
    output addctl_t ctl
);
    always_comb begin
        step = recode(low_bit, hist_bit);
        ctl  = step_to_ctl(step);
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int WD = 9
) (
    input  logic [WD-1:0] acc,
    input  logic [WD-1:0] operand,
    input  addctl_t       ctl,
    output logic [WD-1:0] sum
);
    logic [WD-1:0] operand_eff;
    logic [WD-1:0] cin_vec;

    always_comb begin
        operand_eff = operand ^ {WD{ctl.invert}};
        cin_vec     = {{(WD-1){1'b0}}, ctl.carry_in};
        if (ctl.enable) begin
            sum = acc + operand_eff + cin_vec;
        end else begin
            sum = acc;
        end
    end
endmodule

// File: rtl/booth_ashr.sv
module booth_ashr #(
    parameter int W = 8
) (
    input  logic [W:0]   acc_in,
    input  logic [W-1:0] mreg_in,
    output logic [W:0]   acc_out,
    output logic [W-1:0] mreg_out,
    output logic         hist_out
);
    localparam int AW = W + 1;

    assign acc_out[AW-1] = acc_in[AW-1];
    assign hist_out      = mreg_in[0];

    for (genvar i = 0; i < AW - 1; i++) begin : g_acc
        assign acc_out[i] = acc_in[i+1];
    end

    for (genvar i = 0; i < W; i++) begin : g_mreg
        if (i == W - 1) begin : g_top
            assign mreg_out[i] = acc_in[0];
        end else begin : g_mid
            assign mreg_out[i] = mreg_in[i+1];
        end
    end
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl
    import booth_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          load,
    output logic          busy,
    output logic          last,
    output logic [CW-1:0] cnt,
    output logic          done
);
    localparam logic [CW-1:0] STEPS = CW'(W);
    localparam logic [CW-1:0] ONE   = CW'(1);

    state_e state;

    assign busy = (state == ST_RUN);
    assign load = (state == ST_IDLE) && start;
    assign last = busy && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        cnt   <= STEPS;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt - ONE;
                    if (cnt == ONE) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
    import booth_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   multiplicand,
    input  logic [W-1:0]   multiplier,
    output logic [2*W-1:0] product,
    output logic           done
);
    localparam int AW = W + 1;
    localparam int CW = $clog2(W + 1);

    logic [AW-1:0] ac;
    logic [AW-1:0] mc;
    logic [W-1:0]  qr;
    logic          qx;

    logic          load;
    logic          busy;
    logic          last;
    logic [CW-1:0] cnt;

    step_e         step;
    addctl_t       ctl;
    logic [AW-1:0] sum;
    logic [AW-1:0] ac_n;
    logic [W-1:0]  qr_n;
    logic          qx_n;

    booth_seq_ctrl #(.W(W), .CW(CW)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .busy  (busy),
        .last  (last),
        .cnt   (cnt),
        .done  (done)
    );

    booth_recode u_recode (
        .low_bit  (qr[0]),
        .hist_bit (qx),
        .step     (step),
        .ctl      (ctl)
    );

    booth_addsub #(.WD(AW)) u_addsub (
        .acc     (ac),
        .operand (mc),
        .ctl     (ctl),
        .sum     (sum)
    );

    booth_ashr #(.W(W)) u_ashr (
        .acc_in   (sum),
        .mreg_in  (qr),
        .acc_out  (ac_n),
        .mreg_out (qr_n),
        .hist_out (qx_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ac      <= '0;
            mc      <= '0;
            qr      <= '0;
            qx      <= 1'b0;
            product <= '0;
        end else if (load) begin
            ac <= '0;
            mc <= {multiplicand[W-1], multiplicand};
            qr <= multiplier;
            qx <= 1'b0;
        end else if (busy) begin
            ac <= ac_n;
            qr <= qr_n;
            qx <= qx_n;
            if (last) begin
                product <= {ac_n[W-1:0], qr_n};
            end
        end
    end
endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           done,
    input logic [2*W-1:0] product,
    input logic           busy,
    input logic [CW-1:0]  cnt,
    input logic [W:0]     ac,
    input logic [W:0]     mc,
    input logic [W-1:0]   qr,
    input logic           qx
);
    logic [W:0] ref_sub;
    logic [W:0] ref_add;

    always_comb begin
        ref_sub = ac - mc;
        ref_add = ac + mc;
    end

    // R4: a completion pulse is a single cycle
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: the product moves only with a completion pulse
    assert_product_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(product));

    // R3: the counter falls by one per step until the final step
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt > CW'(1)) |=> (busy && cnt == $past(cnt) - CW'(1)));

    // R3: the final step ends the run with a completion pulse
    assert_done_at_end_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == CW'(1)) |=> (done && !busy));

    // R5: a start during a run leaves the captured multiplicand alone
    assert_start_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(mc));

    // R8: the low multiplier bit becomes the history bit
    assert_hist_shift_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (qx == $past(qr[0])));

    // R8: equal pair keeps the accumulator, then shifts with sign fill
    assert_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && (qr[0] == qx)) |=> (ac == {$past(ac[W]), $past(ac[W:1])}));

    // R8: pair 10 subtracts the multiplicand before the shift
    assert_sub_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && qr[0] && !qx) |=> (ac == {$past(ref_sub[W]), $past(ref_sub[W:1])}));

    // R8: pair 01 adds the multiplicand before the shift
    assert_add_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !qr[0] && qx) |=> (ac == {$past(ref_add[W]), $past(ref_add[W:1])}));

endmodule

bind booth_seq_mul booth_seq_mul_chk #(.W(W), .CW($clog2(W + 1))) u_chk (.*);

// File: tb/test_booth_seq_mul.sv
module test_booth_seq_mul;
    localparam int W  = 6;
    localparam int PW = 2 * W;
    localparam int HALF = 1 << (W - 1);
    localparam int FULL = 1 << W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [W-1:0]  multiplicand = '0;
    logic [W-1:0]  multiplier = '0;
    logic [PW-1:0] product;
    logic          done;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    booth_seq_mul #(.W(W)) i_booth_seq_mul (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .multiplicand (multiplicand),
        .multiplier   (multiplier),
        .product      (product),
        .done         (done)
    );

    function automatic int sval(input int raw);
        return (raw >= HALF) ? raw - FULL : raw;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // run one multiplication; optional disturbance while busy
    task automatic run_mul(input int a, input int b, input bit disturb, output int lat);
        lat = 0;
        @(negedge clk);
        multiplicand = W'(a);
        multiplier   = W'(b);
        start        = 1'b1;
        while (1) begin
            @(negedge clk);
            lat++;
            start = 1'b0;
            if (disturb && lat >= 2 && lat <= W - 1) begin
                start        = 1'b1;
                multiplicand = W'(a + 5);
                multiplier   = W'(b + 7);
            end
            if (done) break;
            if (lat > 4 * W + 20) begin
                check(1'b0, "watchdog", lat, W + 1);
                finish_run();
            end
        end
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int lat;
        logic signed [PW-1:0] exp_p;
        logic [PW-1:0] held;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0 && product == '0, "R1 during reset", product, 0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && product == '0, "R1 after reset", product, 0);

        // R7: 3 * -4
        run_mul(3, -4, 1'b0, lat);
        check(product == 12'hFF4, "R7 3*-4", product, 12'hFF4);
        check(lat == W + 1, "R3 latency 3*-4", lat, W + 1);
        @(negedge clk);
        check(done == 1'b0, "R4 pulse width", done, 0);

        // R6: operand changes while idle leave the product alone
        held = product;
        multiplicand = 6'h15;
        multiplier   = 6'h2A;
        repeat (8) @(negedge clk);
        check(product == held && !done, "R6 idle hold", product, held);

        // R5: start pulses during a run are ignored
        run_mul(-32, 31, 1'b1, lat);
        exp_p = PW'(-32 * 31);
        check(product == exp_p, "R5 result under disturbance", product, exp_p);
        check(lat == W + 1, "R5 latency under disturbance", lat, W + 1);
        start = 1'b0;
        held = product;
        for (int k = 0; k < W + 3; k++) begin
            @(negedge clk);
            check(!done && product == held, "R5 no extra completion", done, 0);
        end

        // R2 corner: most negative squared, zero, ones
        run_mul(-32, -32, 1'b0, lat);
        check(product == PW'(1024), "R2 min*min", product, 1024);
        run_mul(0, -32, 1'b0, lat);
        check(product == '0, "R2 zero*min", product, 0);
        run_mul(-1, -1, 1'b0, lat);
        check(product == PW'(1), "R2 -1*-1", product, 1);
        run_mul(1, -32, 1'b0, lat);
        check(product == PW'(-32), "R2 1*min", product, -32);

        // R2/R3/R4/R8: exhaustive sweep
        for (int a = 0; a < FULL; a++) begin
            for (int b = 0; b < FULL; b++) begin
                run_mul(a, b, 1'b0, lat);
                exp_p = PW'(sval(a) * sval(b));
                check(product == exp_p, "R2 R8 sweep product", longint'($signed(product)), longint'(exp_p));
                check(lat == W + 1, "R3 sweep latency", lat, W + 1);
            end
        end
        @(negedge clk);
        check(done == 1'b0, "R4 pulse width after sweep", done, 0);

        finish_run();
    end
endmodule